// File: doc/BRIEF.md
# Ballast Operating Mode Sequencer

This block is the mode state machine of a fluorescent lamp ballast controller. It takes registered comparator flags for the supply, the preheat timing capacitor, the shutdown/end-of-life pin, the DC bus and the half-bridge overcurrent event counter. It steps the ballast through five modes: undervoltage lockout, filament preheat, lamp ignition, steady run and a latched fault. The analog oscillator, the thresholds and the counter itself are outside the block. The sequencer only decides which of them are active.

The timing capacitor is used twice. Its first rise above the upper threshold ends preheat. The sequencer then forces the capacitor down until it reports below the lower threshold, and ignition starts when that discharge is released. The second rise above the upper threshold ends ignition and starts run.

Leaving a fault needs either a supply drop or a shutdown-pin pulse that goes high and then returns low. The high level sends the machine to lockout, and the low level is the release condition for a restart.

A bus undervoltage seen in run mode raises a supply-discharge request. That request holds the machine in lockout until the supply has fallen below its turn-off threshold.

Top module: `ballast_mode_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mode` is 0 (lockout). In that state `cap_dis` and `vco_clamp` are 1, and every other control output is 0.
- R2: From lockout, `mode` becomes 1 (preheat) one clock after `vcc_on` and `sd_lo` are both 1. If either flag is 0, the machine stays in lockout.
- R3: In lockout (0) and fault (4), `hb_en`, `pfc_en`, `ph_sw`, `pfc_hi_gain`, `cnt_en` and `ign_reg_en` are 0, and `cap_dis` and `vco_clamp` are 1.
- R4: In preheat, `hb_en`, `vco_clamp`, `ph_sw`, `pfc_en`, `pfc_hi_gain` and `cnt_en` are 1, and `ign_reg_en` is 0. `cap_dis` stays 0 until the first `cap_hi`.
- R5: In preheat, `cap_hi` sets `cap_dis` to 1 one clock later while `mode` stays 1. During the discharge a further `cap_hi` changes nothing. `cap_lo` then moves `mode` to 2 (ignition) with `cap_dis` back at 0.
- R6: In ignition, `hb_en`, `pfc_en`, `pfc_hi_gain` and `ign_reg_en` are 1, and `vco_clamp`, `ph_sw`, `cnt_en` and `cap_dis` are 0. `cap_hi` moves `mode` to 3 (run).
- R7: In run, `hb_en`, `pfc_en` and `cnt_en` are 1, and `pfc_hi_gain`, `ign_reg_en`, `vco_clamp`, `ph_sw` and `cap_dis` are 0.
- R8: In run, `eol_hi` or `eol_lo` moves `mode` to 4 (fault). In ignition, `eol_hi`, `eol_lo`, `sd_hi`, `oc_trip` and `bus_uv` have no effect, and `mode` stays 2.
- R9: `oc_trip` in preheat (including its discharge phase) or in run moves `mode` to 4 one clock later.
- R10: Fault is held whatever `vcc_on`, `cap_hi`, `cap_lo`, `oc_trip`, `bus_uv` and the end-of-life flags do. It returns to lockout on `sd_hi` or on `vcc_ok` low. A restart then needs `sd_lo` again.
- R11: `vcc_ok` low sends preheat, ignition or run to lockout. `sd_hi` sends preheat or run to lockout. Both of these take priority over fault entry.
- R12: `bus_uv` in run (with `vcc_ok` 1 and `sd_hi` 0) sends `mode` to 0 and sets `sup_dis`. `sup_dis` stays 1, and the machine stays in lockout even with `vcc_on` and `sd_lo` at 1, until `vcc_ok` is 0. `bus_uv` in preheat has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on | input | 1 | Supply above turn-on threshold |
| vcc_ok | input | 1 | Supply above turn-off threshold |
| cap_hi | input | 1 | Timing capacitor above upper threshold |
| cap_lo | input | 1 | Timing capacitor below lower threshold |
| sd_hi | input | 1 | Shutdown pin above its high threshold |
| sd_lo | input | 1 | Shutdown pin below its low threshold |
| eol_hi | input | 1 | End-of-life pin above upper window |
| eol_lo | input | 1 | End-of-life pin below lower window |
| bus_uv | input | 1 | DC bus below undervoltage threshold |
| oc_trip | input | 1 | Overcurrent event counter has tripped |
| mode | output | 3 | Mode code: 0 lockout, 1 preheat, 2 ignition, 3 run, 4 fault |
| hb_en | output | 1 | Half-bridge drivers enabled |
| cap_dis | output | 1 | Discharge timing capacitor |
| vco_clamp | output | 1 | Hold VCO pin at ground |
| ph_sw | output | 1 | Connect preheat frequency resistor |
| pfc_en | output | 1 | PFC driver enabled |
| pfc_hi_gain | output | 1 | PFC loop high-gain select |
| cnt_en | output | 1 | Overcurrent event counter enabled |
| ign_reg_en | output | 1 | Ignition current regulation enabled |
| sup_dis | output | 1 | Request supply discharge to lockout |

## Verification
A lost or wrong discharge-phase bit shows up at `cap_dis` in the cycle after the first `cap_hi`. It also shows up as ignition being entered too early, or never, so the double crossing is checked step by step. A wrong mode register is visible at `mode` and at the output pattern one clock after the stimulus. Ignored stimuli are therefore checked by reading `mode` and the full output vector in the next cycle. A supply-discharge latch that clears too early shows up as a restart from lockout while `vcc_ok` is still 1. A latch that never clears shows up as no restart after the supply drops.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam int MODE_W = 3;
  localparam int DRV_W  = 9;

  typedef enum logic [MODE_W-1:0] {
    M_UVLO     = 3'd0,
    M_PREHEAT  = 3'd1,
    M_IGNITION = 3'd2,
    M_RUN      = 3'd3,
    M_FAULT    = 3'd4
  } mode_t;

  typedef struct packed {
    logic hb_en;
    logic cap_dis;
    logic vco_clamp;
    logic ph_sw;
    logic pfc_en;
    logic pfc_hi_gain;
    logic cnt_en;
    logic ign_reg_en;
  } drive_t;
endpackage

// File: rtl/bms_mode_fsm.sv
module bms_mode_fsm
  import bms_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  vcc_on,
  input  logic  vcc_ok,
  input  logic  cap_hi,
  input  logic  cap_lo,
  input  logic  sd_hi,
  input  logic  sd_lo,
  input  logic  eol_hi,
  input  logic  eol_lo,
  input  logic  bus_uv,
  input  logic  oc_trip,
  output mode_t mode_q,
  output mode_t mode_d,
  output logic  dsc_q,
  output logic  dsc_d,
  output logic  sdr_q
);
  logic sdr_d;
  logic drop;

  assign drop = !vcc_ok || sd_hi;

  always_comb begin
    mode_d = mode_q;
    dsc_d  = dsc_q;
    sdr_d  = sdr_q && vcc_ok;
    case (mode_q)
      M_UVLO: begin
        dsc_d = 1'b0;
        if (vcc_on && sd_lo && !sdr_q) mode_d = M_PREHEAT;
      end
      M_PREHEAT: begin
        if (drop) begin
          mode_d = M_UVLO;
          dsc_d  = 1'b0;
        end else if (oc_trip) begin
          mode_d = M_FAULT;
          dsc_d  = 1'b0;
        end else if (!dsc_q) begin
          if (cap_hi) dsc_d = 1'b1;
        end else if (cap_lo) begin
          mode_d = M_IGNITION;
          dsc_d  = 1'b0;
        end
      end
      M_IGNITION: begin
        if (!vcc_ok)     mode_d = M_UVLO;
        else if (cap_hi) mode_d = M_RUN;
      end
      M_RUN: begin
        if (drop) begin
          mode_d = M_UVLO;
        end else if (bus_uv) begin
          mode_d = M_UVLO;
          sdr_d  = 1'b1;
        end else if (oc_trip || eol_hi || eol_lo) begin
          mode_d = M_FAULT;
        end
      end
      M_FAULT: begin
        if (drop) mode_d = M_UVLO;
      end
      default: begin
        mode_d = M_UVLO;
        dsc_d  = 1'b0;
        sdr_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_UVLO;
      dsc_q  <= 1'b0;
      sdr_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dsc_q  <= dsc_d;
      sdr_q  <= sdr_d;
    end
  end

  AST_PREHEAT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PREHEAT && $past(mode_q) == M_UVLO) |-> $past(vcc_on && sd_lo)); // R2

  AST_RUN_FROM_IGNITION: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RUN && $past(mode_q) != M_RUN) |-> $past(mode_q) == M_IGNITION); // R6

  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_FAULT && $past(mode_q) != M_FAULT)
      |-> ($past(mode_q) == M_PREHEAT || $past(mode_q) == M_RUN)); // R9

  AST_IGNITION_IMMUNE: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == M_IGNITION && $past(vcc_ok) && !$past(cap_hi))
      |-> mode_q == M_IGNITION); // R8

  AST_SUPPLY_DISCHARGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    sdr_q |-> mode_q == M_UVLO); // R12
endmodule

// File: rtl/bms_drive_reg.sv
module bms_drive_reg
  import bms_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  mode_t  mode_d,
  input  logic   dsc_d,
  input  mode_t  mode_now,
  output drive_t drv_q
);
  drive_t drv_d;
  drive_t drv_idle;

  always_comb begin
    drv_idle           = '0;
    drv_idle.cap_dis   = 1'b1;
    drv_idle.vco_clamp = 1'b1;
    drv_d = drv_idle;
    case (mode_d)
      M_PREHEAT: begin
        drv_d             = '0;
        drv_d.hb_en       = 1'b1;
        drv_d.cap_dis     = dsc_d;
        drv_d.vco_clamp   = 1'b1;
        drv_d.ph_sw       = 1'b1;
        drv_d.pfc_en      = 1'b1;
        drv_d.pfc_hi_gain = 1'b1;
        drv_d.cnt_en      = 1'b1;
      end
      M_IGNITION: begin
        drv_d             = '0;
        drv_d.hb_en       = 1'b1;
        drv_d.pfc_en      = 1'b1;
        drv_d.pfc_hi_gain = 1'b1;
        drv_d.ign_reg_en  = 1'b1;
      end
      M_RUN: begin
        drv_d        = '0;
        drv_d.hb_en  = 1'b1;
        drv_d.pfc_en = 1'b1;
        drv_d.cnt_en = 1'b1;
      end
      default: drv_d = drv_idle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= drv_idle;
    else     drv_q <= drv_d;
  end

  AST_GATES_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mode_now == M_UVLO || mode_now == M_FAULT)
      |-> (!drv_q.hb_en && !drv_q.pfc_en && drv_q.cap_dis && drv_q.vco_clamp)); // R3

  AST_IGN_REG_ONLY_IGNITION: assert property (@(posedge clk) disable iff (rst)
    drv_q.ign_reg_en |-> mode_now == M_IGNITION); // R6

  AST_HIGH_GAIN_NOT_RUN: assert property (@(posedge clk) disable iff (rst)
    (mode_now == M_RUN) |-> (!drv_q.pfc_hi_gain && drv_q.cnt_en)); // R7
endmodule

// File: rtl/ballast_mode_seq.sv
module ballast_mode_seq
  import bms_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vcc_on,
  input  logic              vcc_ok,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic              sd_hi,
  input  logic              sd_lo,
  input  logic              eol_hi,
  input  logic              eol_lo,
  input  logic              bus_uv,
  input  logic              oc_trip,
  output logic [MODE_W-1:0] mode,
  output logic              hb_en,
  output logic              cap_dis,
  output logic              vco_clamp,
  output logic              ph_sw,
  output logic              pfc_en,
  output logic              pfc_hi_gain,
  output logic              cnt_en,
  output logic              ign_reg_en,
  output logic              sup_dis
);
  mode_t  mode_q;
  mode_t  mode_d;
  logic   dsc_q;
  logic   dsc_d;
  logic   sdr_q;
  drive_t drv_q;

  bms_mode_fsm i_fsm (
    .clk     (clk),
    .rst     (rst),
    .vcc_on  (vcc_on),
    .vcc_ok  (vcc_ok),
    .cap_hi  (cap_hi),
    .cap_lo  (cap_lo),
    .sd_hi   (sd_hi),
    .sd_lo   (sd_lo),
    .eol_hi  (eol_hi),
    .eol_lo  (eol_lo),
    .bus_uv  (bus_uv),
    .oc_trip (oc_trip),
    .mode_q  (mode_q),
    .mode_d  (mode_d),
    .dsc_q   (dsc_q),
    .dsc_d   (dsc_d),
    .sdr_q   (sdr_q)
  );

  bms_drive_reg i_drv (
    .clk      (clk),
    .rst      (rst),
    .mode_d   (mode_d),
    .dsc_d    (dsc_d),
    .mode_now (mode_q),
    .drv_q    (drv_q)
  );

  assign mode        = mode_q;
  assign hb_en       = drv_q.hb_en;
  assign cap_dis     = drv_q.cap_dis;
  assign vco_clamp   = drv_q.vco_clamp;
  assign ph_sw       = drv_q.ph_sw;
  assign pfc_en      = drv_q.pfc_en;
  assign pfc_hi_gain = drv_q.pfc_hi_gain;
  assign cnt_en      = drv_q.cnt_en;
  assign ign_reg_en  = drv_q.ign_reg_en;
  assign sup_dis     = sdr_q;

  AST_DISCHARGE_ONLY_PREHEAT: assert property (@(posedge clk) disable iff (rst)
    (dsc_q && mode_q != M_PREHEAT) |-> 1'b0); // R5
endmodule

// File: tb/test_ballast_mode_seq.sv
`timescale 1ns/1ps
module test_ballast_mode_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_on = 0, vcc_ok = 0, cap_hi = 0, cap_lo = 0, sd_hi = 0, sd_lo = 0;
  logic eol_hi = 0, eol_lo = 0, bus_uv = 0, oc_trip = 0;
  logic [2:0] mode;
  logic hb_en, cap_dis, vco_clamp, ph_sw, pfc_en, pfc_hi_gain, cnt_en, ign_reg_en, sup_dis;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [8:0] O_IDLE = 9'b011000000;
  localparam logic [8:0] O_UVSD = 9'b011000001;
  localparam logic [8:0] O_PH   = 9'b101111100;
  localparam logic [8:0] O_PHD  = 9'b111111100;
  localparam logic [8:0] O_IGN  = 9'b100011010;
  localparam logic [8:0] O_RUN  = 9'b100010100;

  always #2.5 clk = ~clk;

  ballast_mode_seq i_ballast_mode_seq (
    .clk(clk), .rst(rst), .vcc_on(vcc_on), .vcc_ok(vcc_ok), .cap_hi(cap_hi),
    .cap_lo(cap_lo), .sd_hi(sd_hi), .sd_lo(sd_lo), .eol_hi(eol_hi),
    .eol_lo(eol_lo), .bus_uv(bus_uv), .oc_trip(oc_trip), .mode(mode),
    .hb_en(hb_en), .cap_dis(cap_dis), .vco_clamp(vco_clamp), .ph_sw(ph_sw),
    .pfc_en(pfc_en), .pfc_hi_gain(pfc_hi_gain), .cnt_en(cnt_en),
    .ign_reg_en(ign_reg_en), .sup_dis(sup_dis)
  );

  function automatic logic [8:0] outs();
    return {hb_en, cap_dis, vco_clamp, ph_sw, pfc_en, pfc_hi_gain, cnt_en, ign_reg_en, sup_dis};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [2:0] em, input logic [8:0] eo);
    n_chk++;
    if (mode !== em || outs() !== eo) begin
      n_fail++;
      $display("FAIL %s: mode=%0d outs=%b expected mode=%0d outs=%b", tag, mode, outs(), em, eo);
    end
  endtask

  task automatic quiet();
    cap_hi = 0; cap_lo = 0; sd_hi = 0; eol_hi = 0; eol_lo = 0; bus_uv = 0; oc_trip = 0;
  endtask

  task automatic go_run();
    quiet();
    vcc_on = 1; vcc_ok = 1; sd_lo = 1;
    tick(); chk("R2 start", 3'd1, O_PH);
    cap_hi = 1; tick(); chk("R5 first crossing", 3'd1, O_PHD);
    cap_hi = 0; cap_lo = 1; tick(); chk("R5 ignition entry", 3'd2, O_IGN);
    cap_lo = 0; cap_hi = 1; tick(); chk("R6 run entry", 3'd3, O_RUN);
    cap_hi = 0;
  endtask

  task automatic go_uvlo();
    quiet();
    vcc_on = 0; vcc_ok = 0; sd_lo = 0;
    tick(); tick();
  endtask

  task automatic t_reset();
    rst = 1; tick(); chk("R1 during reset", 3'd0, O_IDLE);
    rst = 0; tick(); chk("R1 after reset", 3'd0, O_IDLE);
  endtask

  task automatic t_start_gate();
    vcc_on = 1; vcc_ok = 1; sd_lo = 0;
    tick(); tick(); chk("R2 no sd_lo", 3'd0, O_IDLE);
    vcc_on = 0; sd_lo = 1;
    tick(); tick(); chk("R2 no vcc_on", 3'd0, O_IDLE);
    vcc_on = 1; tick(); chk("R2 R4 preheat", 3'd1, O_PH);
    bus_uv = 1; tick(); chk("R12 bus_uv ignored in preheat", 3'd1, O_PH);
    go_uvlo();
  endtask

  task automatic t_double_crossing();
    quiet(); vcc_on = 1; vcc_ok = 1; sd_lo = 1;
    tick(); chk("R4 preheat", 3'd1, O_PH);
    tick(); chk("R4 preheat hold", 3'd1, O_PH);
    cap_hi = 1; tick(); chk("R5 discharge", 3'd1, O_PHD);
    tick(); chk("R5 second cap_hi ignored", 3'd1, O_PHD);
    cap_hi = 0; tick(); chk("R5 waiting lower", 3'd1, O_PHD);
    cap_lo = 1; tick(); chk("R5 R6 ignition", 3'd2, O_IGN);
    cap_lo = 0; tick(); chk("R6 ignition hold", 3'd2, O_IGN);
    cap_hi = 1; tick(); chk("R6 R7 run", 3'd3, O_RUN);
    cap_hi = 0; tick(); chk("R7 run hold", 3'd3, O_RUN);
    go_uvlo();
  endtask

  task automatic t_ign_immune();
    quiet(); vcc_on = 1; vcc_ok = 1; sd_lo = 1;
    tick(); cap_hi = 1; tick(); cap_hi = 0; cap_lo = 1; tick(); cap_lo = 0;
    chk("R8 in ignition", 3'd2, O_IGN);
    eol_hi = 1; tick(); chk("R8 eol_hi ignored", 3'd2, O_IGN);
    eol_hi = 0; eol_lo = 1; tick(); chk("R8 eol_lo ignored", 3'd2, O_IGN);
    eol_lo = 0; oc_trip = 1; tick(); chk("R8 oc ignored", 3'd2, O_IGN);
    oc_trip = 0; sd_lo = 0; sd_hi = 1; tick(); chk("R8 sd_hi ignored", 3'd2, O_IGN);
    sd_hi = 0; bus_uv = 1; tick(); chk("R8 bus_uv ignored", 3'd2, O_IGN);
    bus_uv = 0; vcc_ok = 0; vcc_on = 0; tick(); chk("R11 ignition supply drop", 3'd0, O_IDLE);
    go_uvlo();
  endtask

  task automatic t_eol_fault();
    go_run();
    eol_hi = 1; tick(); chk("R8 eol_hi fault", 3'd4, O_IDLE);
    eol_hi = 0; vcc_on = 0; cap_hi = 1; oc_trip = 1; bus_uv = 1; eol_lo = 1;
    tick(); tick(); chk("R10 fault held", 3'd4, O_IDLE);
    quiet(); sd_lo = 0; sd_hi = 1; tick(); chk("R10 sd_hi exit", 3'd0, O_IDLE);
    vcc_on = 1; tick(); chk("R10 no restart without sd_lo", 3'd0, O_IDLE);
    sd_hi = 0; sd_lo = 1; tick(); chk("R10 restart", 3'd1, O_PH);
    go_uvlo();
    go_run();
    eol_lo = 1; tick(); chk("R8 eol_lo fault", 3'd4, O_IDLE);
    eol_lo = 0; vcc_ok = 0; vcc_on = 0; tick(); chk("R10 supply exit", 3'd0, O_IDLE);
    go_uvlo();
  endtask

  task automatic t_oc_fault();
    quiet(); vcc_on = 1; vcc_ok = 1; sd_lo = 1;
    tick(); oc_trip = 1; tick(); chk("R9 oc in preheat", 3'd4, O_IDLE);
    go_uvlo();
    quiet(); vcc_on = 1; vcc_ok = 1; sd_lo = 1;
    tick(); cap_hi = 1; tick(); cap_hi = 0;
    oc_trip = 1; tick(); chk("R9 oc in discharge", 3'd4, O_IDLE);
    go_uvlo();
    go_run();
    oc_trip = 1; tick(); chk("R9 oc in run", 3'd4, O_IDLE);
    go_uvlo();
  endtask

  task automatic t_drop_priority();
    quiet(); vcc_on = 1; vcc_ok = 1; sd_lo = 1;
    tick(); sd_lo = 0; sd_hi = 1; oc_trip = 1; tick();
    chk("R11 preheat sd_hi over oc", 3'd0, O_IDLE);
    go_uvlo();
    go_run();
    vcc_on = 0; vcc_ok = 0; eol_hi = 1; tick();
    chk("R11 run supply drop over eol", 3'd0, O_IDLE);
    go_uvlo();
    go_run();
    sd_lo = 0; sd_hi = 1; bus_uv = 1; tick();
    chk("R11 run sd_hi over bus_uv", 3'd0, O_IDLE);
    go_uvlo();
  endtask

  task automatic t_bus_uv();
    go_run();
    bus_uv = 1; oc_trip = 1; tick(); chk("R12 bus_uv to lockout", 3'd0, O_UVSD);
    bus_uv = 0; oc_trip = 0; tick(); tick(); chk("R12 request held", 3'd0, O_UVSD);
    vcc_on = 0; vcc_ok = 0; tick(); chk("R12 request cleared", 3'd0, O_IDLE);
    vcc_on = 1; vcc_ok = 1; tick(); chk("R12 restart after clear", 3'd1, O_PH);
    go_uvlo();
  endtask

  initial begin
    #1;
    t_reset();
    t_start_gate();
    t_double_crossing();
    t_ign_immune();
    t_eol_fault();
    t_oc_fault();
    t_drop_priority();
    t_bus_uv();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule